// File: doc/BRIEF.md
# I2C Random-Read Sequencer

This block performs a complete random read from an I2C target, such as a serial EEPROM, with no processor involvement. It drives the byte-wide register port of a status-code I2C master: it writes the master's reset, address, clock-divider, data and control registers, and after each bus step it polls the master's status code until that code matches the one value the step expects. The master handles all bit-level bus timing; this block only orders the steps and judges their outcomes.

A one-cycle `start` pulse latches the target address, a 16-bit offset, the offset width and the byte count. The block then runs the full sequence: initialise, START, address for write, offset bytes, repeated START, address for read, data reads, STOP. It streams each received byte out with a one-cycle strobe and finishes with a one-cycle `done`. If a status code does not match within the polling budget, the block writes STOP to the master, raises `error` together with `done`, and returns to idle.

Top module: `i2c_rand_reader`

## Requirements
- R1: After a start pulse in idle, the first writes are, one per cycle: reset select 5 with 0x00, own-address select 0 with 0x00, extended-address select 1 with 0x00, divider select 4 with BAUD_VAL (default 0x24), and control select 3 with 0x40 (enable, bit 6). The expected status after that control write is 0xF8.
- R2: The block then writes control 0x60 (START bit 5 plus enable) and expects 0x08. It writes data select 2 with {address, 0}, then control 0x40, and expects 0x18.
- R3: With wideOffset = 1, the block sends the high offset byte and then the low offset byte. With wideOffset = 0, it sends only the low byte. Each byte is a data write followed by control 0x40, and each expects 0x28.
- R4: After the offset, the block writes control 0x60 and expects 0x10 (repeated START). It then writes data {address, 1}, then control 0x40, and expects 0x40.
- R5: Every data byte except the last is requested with control 0x44 (ACK bit 2 plus enable) and expects 0x50. The last byte is requested with control 0x40 and expects 0x58. The block then writes control 0x50 (STOP bit 4 plus enable), expects 0xF8, and pulses done for one cycle with error low.
- R6: Each received byte appears on byteOut with byteValid high for one cycle, in reception order. The byte is sampled from rxData in the poll where its expected status is seen.
- R7: A byteCount of 0 is treated as 1, so exactly one byte is read, with the NACK request.
- R8: After each control write, the block samples the status every POLL_GAP cycles, for at most MAX_POLLS samples. The first sample is taken POLL_GAP cycles after the write. A match on the last allowed sample is accepted.
- R9: If no sample matches, or if a wrong code is held, the block writes control 0x50 one cycle after the final sample. In the next cycle it asserts done and error together, and it then returns to idle.
- R10: A start pulse while a read is in progress has no effect: the running sequence uses the values latched at its own start, and no second sequence follows.
- R11: After every control write there is a cycle with no register write, and done is high for one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a read |
| devAddr | input | 7 | 7-bit target address |
| offset | input | 16 | Byte offset inside the target |
| wideOffset | input | 1 | 1 = two offset bytes, 0 = one |
| byteCount | input | CNT_W | Number of bytes to read (0 reads one) |
| regWrEn | output | 1 | Register write strobe to the master |
| regSel | output | 3 | Register select for the write |
| regData | output | 8 | Write data |
| statusCode | input | 8 | Master status register contents |
| rxData | input | 8 | Master data register contents |
| byteOut | output | 8 | Received byte |
| byteValid | output | 1 | byteOut strobe |
| done | output | 1 | Sequence finished (one cycle) |
| error | output | 1 | High with done when the read aborted |

## Verification
The status sample for a step is due POLL_GAP cycles after its control write, and again every POLL_GAP cycles after that. A received byte shows on byteOut one cycle after the sample that accepts it. A successful read raises done one cycle after the STOP status is accepted. On a timeout, the abort STOP write comes exactly POLL_GAP·MAX_POLLS+1 cycles after the failing control write, and done with error follows one cycle later. The bench's master model counts its response latency from the cycle in which it sees a control write, and compares every write against a trace it builds from the requirements. The two latencies on either side of the last allowed sample (12 and 13 cycles with the bench parameters) pin the polling window to the cycle. The abort-write cycle is measured against the failing control-write cycle, and all ports are sampled on the falling edge.

// File: rtl/i2c_rr_pkg.sv
package i2c_rr_pkg;

  // register selects decoded by the master's register port
  typedef enum logic [2:0] {
    SEL_OWN  = 3'd0,
    SEL_EXT  = 3'd1,
    SEL_DATA = 3'd2,
    SEL_CTRL = 3'd3,
    SEL_BAUD = 3'd4,
    SEL_RST  = 3'd5
  } regSel_t;

  // control register bits
  localparam logic [7:0] CB_ACK   = 8'h04;
  localparam logic [7:0] CB_STOP  = 8'h10;
  localparam logic [7:0] CB_START = 8'h20;
  localparam logic [7:0] CB_EN    = 8'h40;

  // status codes the sequence waits for
  localparam logic [7:0] SC_IDLE     = 8'hF8;
  localparam logic [7:0] SC_START    = 8'h08;
  localparam logic [7:0] SC_RESTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK   = 8'h18;
  localparam logic [7:0] SC_TX_ACK   = 8'h28;
  localparam logic [7:0] SC_AR_ACK   = 8'h40;
  localparam logic [7:0] SC_RX_ACK   = 8'h50;
  localparam logic [7:0] SC_RX_NACK  = 8'h58;

  // source of the write data
  typedef enum logic [2:0] {
    DS_ZERO,
    DS_BAUD,
    DS_CTRL,
    DS_ADDR_W,
    DS_ADDR_R,
    DS_OFF_HI,
    DS_OFF_LO
  } dataSrc_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic arm;
    logic poll;
    logic capture;
  } dpCmd_t;

endpackage

// File: rtl/i2c_rr_dp.sv
module i2c_rr_dp
  import i2c_rr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int POLL_GAP  = 1000,
  parameter int MAX_POLLS = 1000,
  parameter logic [7:0] BAUD_VAL = 8'h24
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  dataSrc_t         dataSrc,
  input  logic [7:0]       ctrlByte,
  input  logic [6:0]       devAddr,
  input  logic [15:0]      offset,
  input  logic             wideOffset,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [7:0]       rxData,
  output logic [7:0]       regData,
  output logic             sampleNow,
  output logic             lastPoll,
  output logic             remOne,
  output logic             wideQ,
  output logic [7:0]       byteOut,
  output logic             byteValid
);

  localparam int GAP_W  = $clog2(POLL_GAP + 1);
  localparam int POLL_W = $clog2(MAX_POLLS + 1);
  localparam logic [GAP_W-1:0]  GAP_RELOAD = GAP_W'(POLL_GAP - 1);
  localparam logic [POLL_W-1:0] POLL_END   = POLL_W'(MAX_POLLS - 1);

  logic [6:0]       devQ;
  logic [15:0]      offQ;
  logic [CNT_W-1:0] remQ;
  logic [GAP_W-1:0] gapCnt;
  logic [POLL_W-1:0] pollCnt;

  // request latch and remaining-byte counter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      devQ  <= '0;
      offQ  <= '0;
      wideQ <= 1'b0;
      remQ  <= CNT_W'(1);
    end else if (cmd.load) begin
      devQ  <= devAddr;
      offQ  <= offset;
      wideQ <= wideOffset;
      remQ  <= (byteCount == '0) ? CNT_W'(1) : byteCount;
    end else if (cmd.capture) begin
      remQ  <= remQ - CNT_W'(1);
    end
  end

  // poll spacing and poll budget
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt  <= '0;
      pollCnt <= '0;
    end else if (cmd.arm) begin
      gapCnt  <= GAP_RELOAD;
      pollCnt <= '0;
    end else if (cmd.poll) begin
      if (gapCnt != '0) begin
        gapCnt <= gapCnt - GAP_W'(1);
      end else begin
        gapCnt  <= GAP_RELOAD;
        pollCnt <= pollCnt + POLL_W'(1);
      end
    end
  end

  assign sampleNow = (gapCnt == '0);
  assign lastPoll  = (pollCnt == POLL_END);
  assign remOne    = (remQ == CNT_W'(1));

  // received byte stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteOut   <= '0;
      byteValid <= 1'b0;
    end else begin
      byteValid <= cmd.capture;
      if (cmd.capture) byteOut <= rxData;
    end
  end

  // write data mux
  always_comb begin
    unique case (dataSrc)
      DS_BAUD:   regData = BAUD_VAL;
      DS_CTRL:   regData = ctrlByte;
      DS_ADDR_W: regData = {devQ, 1'b0};
      DS_ADDR_R: regData = {devQ, 1'b1};
      DS_OFF_HI: regData = offQ[15:8];
      DS_OFF_LO: regData = offQ[7:0];
      default:   regData = 8'h00;
    endcase
  end

endmodule

// File: rtl/i2c_rr_ctrl.sv
module i2c_rr_ctrl
  import i2c_rr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] statusCode,
  input  logic       sampleNow,
  input  logic       lastPoll,
  input  logic       remOne,
  input  logic       wideQ,
  output logic       regWrEn,
  output regSel_t    regSel,
  output dataSrc_t   dataSrc,
  output logic [7:0] ctrlByte,
  output dpCmd_t     cmd,
  output logic       done,
  output logic       error
);

  typedef enum logic [4:0] {
    ST_IDLE, ST_RST, ST_OWN, ST_EXT, ST_BAUD, ST_EN, ST_START,
    ST_AW_D, ST_AW_C, ST_OH_D, ST_OH_C, ST_OL_D, ST_OL_C,
    ST_RS, ST_AR_D, ST_AR_C, ST_RD, ST_WAIT, ST_STOP, ST_ABORT, ST_FIN
  } state_t;

  state_t     state, nxt, retQ, newRet;
  logic [7:0] expQ, newExp;
  logic       errQ;

  always_comb begin
    nxt      = state;
    regWrEn  = 1'b0;
    regSel   = SEL_CTRL;
    dataSrc  = DS_ZERO;
    ctrlByte = 8'h00;
    cmd      = '0;
    newExp   = SC_IDLE;
    newRet   = ST_IDLE;
    done     = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin cmd.load = 1'b1; nxt = ST_RST; end
      ST_RST:  begin regWrEn = 1'b1; regSel = SEL_RST; nxt = ST_OWN;  end
      ST_OWN:  begin regWrEn = 1'b1; regSel = SEL_OWN; nxt = ST_EXT;  end
      ST_EXT:  begin regWrEn = 1'b1; regSel = SEL_EXT; nxt = ST_BAUD; end
      ST_BAUD: begin
        regWrEn = 1'b1; regSel = SEL_BAUD; dataSrc = DS_BAUD; nxt = ST_EN;
      end
      ST_AW_D: begin
        regWrEn = 1'b1; regSel = SEL_DATA; dataSrc = DS_ADDR_W; nxt = ST_AW_C;
      end
      ST_OH_D: begin
        regWrEn = 1'b1; regSel = SEL_DATA; dataSrc = DS_OFF_HI; nxt = ST_OH_C;
      end
      ST_OL_D: begin
        regWrEn = 1'b1; regSel = SEL_DATA; dataSrc = DS_OFF_LO; nxt = ST_OL_C;
      end
      ST_AR_D: begin
        regWrEn = 1'b1; regSel = SEL_DATA; dataSrc = DS_ADDR_R; nxt = ST_AR_C;
      end
      ST_EN, ST_START, ST_AW_C, ST_OH_C, ST_OL_C, ST_RS, ST_AR_C, ST_RD,
      ST_STOP: begin
        regWrEn = 1'b1;
        dataSrc = DS_CTRL;
        cmd.arm = 1'b1;
        nxt     = ST_WAIT;
        ctrlByte = CB_EN;
        case (state)
          ST_EN:    begin newExp = SC_IDLE;    newRet = ST_START; end
          ST_START: begin ctrlByte = CB_START | CB_EN;
                          newExp = SC_START;   newRet = ST_AW_D;  end
          ST_AW_C:  begin newExp = SC_AW_ACK;
                          newRet = wideQ ? ST_OH_D : ST_OL_D;     end
          ST_OH_C:  begin newExp = SC_TX_ACK;  newRet = ST_OL_D;  end
          ST_OL_C:  begin newExp = SC_TX_ACK;  newRet = ST_RS;    end
          ST_RS:    begin ctrlByte = CB_START | CB_EN;
                          newExp = SC_RESTART; newRet = ST_AR_D;  end
          ST_AR_C:  begin newExp = SC_AR_ACK;  newRet = ST_RD;    end
          ST_RD: begin
            if (remOne) begin
              newExp = SC_RX_NACK; newRet = ST_STOP;
            end else begin
              ctrlByte = CB_ACK | CB_EN;
              newExp = SC_RX_ACK;  newRet = ST_RD;
            end
          end
          default:  begin ctrlByte = CB_STOP | CB_EN;
                          newExp = SC_IDLE;    newRet = ST_FIN;   end
        endcase
      end
      ST_WAIT: begin
        cmd.poll = 1'b1;
        if (sampleNow) begin
          if (statusCode == expQ) begin
            nxt = retQ;
            cmd.capture = (expQ == SC_RX_ACK) || (expQ == SC_RX_NACK);
          end else if (lastPoll) begin
            nxt = ST_ABORT;
          end
        end
      end
      ST_ABORT: begin
        regWrEn  = 1'b1;
        dataSrc  = DS_CTRL;
        ctrlByte = CB_STOP | CB_EN;
        nxt      = ST_FIN;
      end
      ST_FIN: begin done = 1'b1; nxt = ST_IDLE; end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      retQ  <= ST_IDLE;
      expQ  <= SC_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= nxt;
      if (cmd.arm) begin
        expQ <= newExp;
        retQ <= newRet;
      end
      if (cmd.load) errQ <= 1'b0;
      else if (state == ST_ABORT) errQ <= 1'b1;
    end
  end

  assign error = done & errQ;

endmodule

// File: rtl/i2c_rand_reader.sv
module i2c_rand_reader
  import i2c_rr_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int POLL_GAP  = 1000,
  parameter int MAX_POLLS = 1000,
  parameter logic [7:0] BAUD_VAL = 8'h24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [6:0]       devAddr,
  input  logic [15:0]      offset,
  input  logic             wideOffset,
  input  logic [CNT_W-1:0] byteCount,
  output logic             regWrEn,
  output logic [2:0]       regSel,
  output logic [7:0]       regData,
  input  logic [7:0]       statusCode,
  input  logic [7:0]       rxData,
  output logic [7:0]       byteOut,
  output logic             byteValid,
  output logic             done,
  output logic             error
);

  dpCmd_t     cmd;
  dataSrc_t   dataSrc;
  regSel_t    selE;
  logic [7:0] ctrlByte;
  logic       sampleNow, lastPoll, remOne, wideQ;

  i2c_rr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .statusCode(statusCode),
    .sampleNow(sampleNow), .lastPoll(lastPoll), .remOne(remOne), .wideQ(wideQ),
    .regWrEn(regWrEn), .regSel(selE), .dataSrc(dataSrc), .ctrlByte(ctrlByte),
    .cmd(cmd), .done(done), .error(error)
  );

  i2c_rr_dp #(
    .CNT_W(CNT_W), .POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS), .BAUD_VAL(BAUD_VAL)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .dataSrc(dataSrc), .ctrlByte(ctrlByte),
    .devAddr(devAddr), .offset(offset), .wideOffset(wideOffset),
    .byteCount(byteCount), .rxData(rxData), .regData(regData),
    .sampleNow(sampleNow), .lastPoll(lastPoll), .remOne(remOne), .wideQ(wideQ),
    .byteOut(byteOut), .byteValid(byteValid)
  );

  assign regSel = selE;

endmodule

// File: rtl/i2c_rr_chk.sv
module i2c_rr_chk (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [2:0] regSel,
  input logic [7:0] regData,
  input logic       byteValid,
  input logic       done,
  input logic       error
);

  // R11: done lasts one cycle
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11: a control write is followed by a quiet cycle
  a_r11_ctrl_gap: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 3'd3) |=> !regWrEn);

  // R9: error only together with done
  a_r9_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R9: error is preceded by a STOP control write
  a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(error) |-> ($past(regWrEn) && $past(regSel) == 3'd3 && $past(regData) == 8'h50));

  // R1: every control write keeps the enable bit set
  a_r1_enable_kept: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 3'd3) |-> regData[6]);

  // R6: byte strobe is a single cycle
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R10: after done the block is idle for at least one cycle
  a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !regWrEn);

endmodule

bind i2c_rand_reader i2c_rr_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
  .regData(regData), .byteValid(byteValid), .done(done), .error(error)
);

// File: tb/tb_i2c_rand_reader.sv
module tb_i2c_rand_reader;

  localparam int GAP = 3;
  localparam int MAXP = 4;
  localparam int NORM_LAT = 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic [6:0] devAddr = '0;
  logic [15:0] offset = '0;
  logic       wideOffset = 1'b0;
  logic [7:0] byteCount = '0;
  logic       regWrEn;
  logic [2:0] regSel;
  logic [7:0] regData;
  logic [7:0] statusCode = 8'h00;
  logic [7:0] rxData = 8'h00;
  logic [7:0] byteOut;
  logic       byteValid, done, error;

  i2c_rand_reader #(.CNT_W(8), .POLL_GAP(GAP), .MAX_POLLS(MAXP), .BAUD_VAL(8'h24)) dut (
    .clk(clk), .rstN(rstN), .start(start), .devAddr(devAddr), .offset(offset),
    .wideOffset(wideOffset), .byteCount(byteCount), .regWrEn(regWrEn),
    .regSel(regSel), .regData(regData), .statusCode(statusCode), .rxData(rxData),
    .byteOut(byteOut), .byteValid(byteValid), .done(done), .error(error)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // expected trace
  logic [2:0] expSel [0:63];
  logic [7:0] expData [0:63];
  logic [7:0] respArr [0:63];
  int nExp, kc, failAtB;
  bit cut;

  // model state
  int lat = NORM_LAT;
  int injectAt = -1;
  int ctrlIdx, nWr, nBad, pendCnt, nBytesTx, nGot, doneCnt, errAtDone;
  int lastCtrlCyc, prevCtrlCyc, doneCyc;
  logic [7:0] pendCode;
  logic [7:0] gotBytes [0:63];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic void pushW(input logic [2:0] s, input logic [7:0] d);
    if (!cut && nExp < 64) begin
      expSel[nExp] = s; expData[nExp] = d; nExp++;
    end
  endfunction

  function automatic void pushC(input logic [7:0] d, input logic [7:0] code);
    if (!cut) begin
      pushW(3'd3, d);
      respArr[kc] = code;
      if (kc == failAtB) cut = 1'b1;
      kc++;
    end
  endfunction

  function automatic void build(input logic [6:0] dev, input logic [15:0] off,
                                input bit wide, input int cnt, input int failAt);
    int n;
    n = (cnt == 0) ? 1 : cnt;
    for (int i = 0; i < 64; i++) respArr[i] = 8'hF8;
    nExp = 0; kc = 0; cut = 1'b0; failAtB = failAt;
    pushW(3'd5, 8'h00); pushW(3'd0, 8'h00); pushW(3'd1, 8'h00); pushW(3'd4, 8'h24);
    pushC(8'h40, 8'hF8);
    pushC(8'h60, 8'h08);
    pushW(3'd2, {dev, 1'b0}); pushC(8'h40, 8'h18);
    if (wide) begin pushW(3'd2, off[15:8]); pushC(8'h40, 8'h28); end
    pushW(3'd2, off[7:0]); pushC(8'h40, 8'h28);
    pushC(8'h60, 8'h10);
    pushW(3'd2, {dev, 1'b1}); pushC(8'h40, 8'h40);
    for (int i = 1; i < n; i++) pushC(8'h44, 8'h50);
    pushC(8'h40, 8'h58);
    pushC(8'h50, 8'hF8);
    if (failAt >= 0) begin cut = 1'b0; pushW(3'd3, 8'h50); end
  endfunction

  // master model and monitors, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      if (pendCnt != 0) begin
        pendCnt--;
        if (pendCnt == 0) begin
          statusCode <= pendCode;
          if (pendCode == 8'h50 || pendCode == 8'h58) begin
            rxData <= 8'hA0 + 8'(nBytesTx);
            nBytesTx++;
          end
        end
      end
      if (regWrEn) begin
        if (nWr >= nExp || regSel != expSel[nWr] || regData != expData[nWr]) nBad++;
        nWr++;
        if (regSel == 3'd3) begin
          prevCtrlCyc = lastCtrlCyc;
          lastCtrlCyc = cyc;
          statusCode <= 8'h00;
          pendCnt = lat;
          pendCode = (ctrlIdx == injectAt) ? 8'h30 :
                     (ctrlIdx < 64 ? respArr[ctrlIdx] : 8'hF8);
          ctrlIdx++;
        end
      end
      if (byteValid && nGot < 64) begin gotBytes[nGot] = byteOut; nGot++; end
      if (done) begin doneCnt++; errAtDone = error; doneCyc = cyc; end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R11 watchdog expired: actual %0d expected %0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // runs one read; poke drives a second start mid-sequence
  task automatic runRead(input logic [6:0] dev, input logic [15:0] off, input bit wide,
                         input int cnt, input int failAt, input bit poke);
    int waitC;
    build(dev, off, wide, cnt, failAt);
    ctrlIdx = 0; nWr = 0; nBad = 0; pendCnt = 0; nBytesTx = 0; nGot = 0;
    doneCnt = 0; errAtDone = 0; lastCtrlCyc = 0; prevCtrlCyc = 0; doneCyc = 0;
    @(negedge clk);
    devAddr = dev; offset = off; wideOffset = wide; byteCount = 8'(cnt); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitC = 0;
    while (doneCnt == 0 && waitC < 3000) begin
      @(negedge clk);
      waitC++;
      if (poke && waitC == 20) begin
        devAddr = 7'h11; offset = 16'hFFFF; wideOffset = ~wide; byteCount = 8'd9;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    check(waitC < 3000, "R11", "sequence finished", waitC, 3000);
    repeat (30) @(negedge clk);
  endtask

  task automatic checkTrace(input string req);
    check(nBad == 0, req, "mismatched register writes", nBad, 0);
    check(nWr == nExp, req, "register write count", nWr, nExp);
  endtask

  task automatic checkBytes(input string req, input int cnt);
    int n;
    int bad;
    n = (cnt == 0) ? 1 : cnt;
    bad = 0;
    check(nGot == n, req, "byte count", nGot, n);
    for (int i = 0; i < nGot && i < n; i++)
      if (gotBytes[i] != 8'hA0 + 8'(i)) bad++;
    check(bad == 0, req, "byte values in order", bad, 0);
    check(doneCnt == 1 && errAtDone == 0, req, "done once without error",
          doneCnt * 10 + errAtDone, 10);
  endtask

  task automatic testReset;
    check(regWrEn == 1'b0, "R1", "no write in reset idle", int'(regWrEn), 0);
    check(done == 1'b0 && error == 1'b0, "R9", "done/error low after reset",
          int'({done, error}), 0);
    check(byteValid == 1'b0, "R6", "no byte after reset", int'(byteValid), 0);
  endtask

  task automatic testNarrow;   // R1 R2 R3 R4 R5 R6
    lat = NORM_LAT; injectAt = -1;
    runRead(7'h50, 16'h1234, 1'b0, 3, -1, 1'b0);
    checkTrace("R1");
    checkBytes("R5", 3);
  endtask

  task automatic testWide;     // R3 wide offset, R6
    lat = NORM_LAT; injectAt = -1;
    runRead(7'h2B, 16'hBEEF, 1'b1, 2, -1, 1'b0);
    checkTrace("R3");
    checkBytes("R6", 2);
  endtask

  task automatic testZeroCount; // R7
    lat = NORM_LAT; injectAt = -1;
    runRead(7'h7F, 16'h00C3, 1'b1, 0, -1, 1'b0);
    checkTrace("R7");
    checkBytes("R7", 0);
  endtask

  task automatic testLastPoll;  // R8: response at the final allowed sample
    lat = GAP * MAXP; injectAt = -1;
    runRead(7'h33, 16'h0042, 1'b0, 1, -1, 1'b0);
    checkTrace("R8");
    checkBytes("R8", 1);
  endtask

  task automatic testTimeout;   // R8 R9: one cycle too late
    lat = GAP * MAXP + 1; injectAt = -1;
    runRead(7'h33, 16'h0042, 1'b0, 1, 0, 1'b0);
    checkTrace("R9");
    check(lastCtrlCyc - prevCtrlCyc == GAP * MAXP + 1, "R8", "abort STOP cycle",
          lastCtrlCyc - prevCtrlCyc, GAP * MAXP + 1);
    check(doneCnt == 1 && errAtDone == 1, "R9", "done with error",
          doneCnt * 10 + errAtDone, 11);
    check(doneCyc - lastCtrlCyc == 1, "R9", "done follows abort STOP",
          doneCyc - lastCtrlCyc, 1);
  endtask

  task automatic testWrongCode; // R9: wrong status at the high-offset step
    lat = NORM_LAT; injectAt = 3;
    runRead(7'h44, 16'hA55A, 1'b1, 2, 3, 1'b0);
    checkTrace("R9");
    check(nGot == 0, "R9", "no bytes after abort", nGot, 0);
    check(doneCnt == 1 && errAtDone == 1, "R9", "wrong code gives error",
          doneCnt * 10 + errAtDone, 11);
    injectAt = -1;
  endtask

  task automatic testBusyStart; // R10
    lat = NORM_LAT; injectAt = -1;
    runRead(7'h21, 16'h0F0F, 1'b0, 2, -1, 1'b1);
    checkTrace("R10");
    checkBytes("R10", 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testNarrow();
    testWide();
    testZeroCount();
    testLastPoll();
    testTimeout();
    testWrongCode();
    testBusyStart();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule